// File: doc/BRIEF.md
# Operating Mode Power Controller

This block turns three active-low mode-select pins into one operating mode. It then drives a registered enable for each circuit group of a dual-standard radio baseband front end. The groups are wideband (spread-spectrum) receive, narrowband (analog FM) receive, wideband transmit, narrowband transmit, the chip-rate clock synthesizer, the reference divider output and the transmit synthesizer. The block also gates the lock-detect output driver, and it issues a fixed-length pulse that starts fast acquisition in the transmit synthesizer.

The pins are asynchronous to the block's clock. They pass through a synchronizer chain and then a stability filter, and only a pattern that has held steady is accepted. Five of the eight pin patterns name steady modes. The other three name transition modes. A transition mode reports its own code but applies the enables of the steady mode it leads to.

Top module: `mpc_top`

## Requirements
- R1: With the pins taken as {nb_sel_n, stby_n, doze_n}, `mode_code` reads as follows. 3'b111 gives 0 (wideband run). 3'b101 gives 1 (wideband standby). 3'b100 gives 2 (wideband doze). 3'b011 gives 3 (narrowband run). 3'b001 gives 4 (narrowband standby). 3'b000 gives 5 (narrowband standby transition). 3'b010 gives 6 (narrowband run transition). 3'b110 gives 7 (wideband doze transition).
- R2: While `rst_n` is low, and until a new pattern is accepted, `mode_code` is 2, only `en_ref_div` is high, and `acq_start` is low.
- R3: A pattern is accepted only after SYNC_STAGES synchronizer flops and STABLE_CYCLES consecutive identical synchronized samples. A pin change made ahead of clock edge k reaches the outputs after edge k+SYNC_STAGES+STABLE_CYCLES (k+4 by default). A pattern that is held for fewer cycles never reaches the outputs.
- R4: Wideband run enables wideband receive, wideband transmit, chip clock, reference divider and transmit synthesizer. Both narrowband enables are low.
- R5: Wideband standby enables only wideband receive, chip clock and the reference divider.
- R6: Wideband doze enables only the reference divider.
- R7: Narrowband run enables narrowband receive, narrowband transmit, chip clock, reference divider and transmit synthesizer. Wideband receive and wideband transmit are low.
- R8: Narrowband standby enables only narrowband receive and the reference divider.
- R9: Codes 5, 6 and 7 apply the enables of codes 4, 3 and 2 respectively.
- R10: `en_chip_clk` is low exactly in codes 2, 4, 5 and 7.
- R11: `lock_drive` is high only in the transmit-active codes 0, 3 and 6. Elsewhere the lock output is released.
- R12: `acq_start` goes high together with the new enables when a code that is not transmit-active is followed by a transmit-active one. It then stays high for ACQ_CYCLES cycles. A change between two transmit-active codes gives no pulse.
- R13: `en_ref_div` is high in every mode and in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nb_sel_n | input | 1 | Low selects the narrowband standard |
| stby_n | input | 1 | Low requests standby |
| doze_n | input | 1 | Low requests doze |
| en_wb_rx | output | 1 | Wideband receive enable |
| en_nb_rx | output | 1 | Narrowband receive enable |
| en_wb_tx | output | 1 | Wideband transmit enable |
| en_nb_tx | output | 1 | Narrowband transmit enable |
| en_chip_clk | output | 1 | Chip-rate synthesizer enable |
| en_ref_div | output | 1 | Reference divider output enable |
| en_tx_synth | output | 1 | Transmit synthesizer enable |
| lock_drive | output | 1 | Lock-detect output driver enable |
| mode_code | output | 3 | Accepted operating mode |
| acq_start | output | 1 | Fast-acquisition start pulse |

## Verification
The embedded properties check, on every cycle, the invariants that hold in any mode. The reference divider is always on, receive and transmit groups never cross standards, and the chip clock is off in its four codes. The lock driver follows the transmit enables, a rising acquisition pulse coincides with a transmit synthesizer turning on, and the accepted pattern never moves without a stable synchronized pair. Only the bench's scenarios can show the exact acceptance latency, the rejection of short glitches, the enable set for each of the eight codes and the pulse length. The scenarios also show that moving directly between the two run modes triggers no acquisition.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

   typedef enum logic [2:0] {
      MD_WB_RUN     = 3'd0,
      MD_WB_STBY    = 3'd1,
      MD_WB_DOZE    = 3'd2,
      MD_NB_RUN     = 3'd3,
      MD_NB_STBY    = 3'd4,
      MD_NB_STBY_TR = 3'd5,
      MD_NB_RUN_TR  = 3'd6,
      MD_WB_DOZE_TR = 3'd7
   } op_mode_e;

   typedef struct packed {
      logic wb_rx;
      logic nb_rx;
      logic wb_tx;
      logic nb_tx;
      logic chip_clk;
      logic ref_div;
      logic tx_synth;
      logic lock_drv;
   } pwr_en_t;

   localparam int  PIN_W      = 3;
   localparam logic [PIN_W-1:0] PINS_AT_RESET = 3'b100;
   localparam pwr_en_t EN_AT_RESET = '{wb_rx: 1'b0, nb_rx: 1'b0, wb_tx: 1'b0,
                                       nb_tx: 1'b0, chip_clk: 1'b0, ref_div: 1'b1,
                                       tx_synth: 1'b0, lock_drv: 1'b0};

endpackage

// File: rtl/mpc_sync.sv
module mpc_sync #(
   parameter int              W       = 3,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o
);

   initial begin : chk_params
      assert (STAGES >= 2) else $error("mpc_sync: STAGES must be at least 2");
      assert (W >= 1)      else $error("mpc_sync: W must be positive");
   end

   logic [W-1:0] stage_q [STAGES];

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[gi] <= RST_VAL;
               else        stage_q[gi] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[gi] <= RST_VAL;
               else        stage_q[gi] <= stage_q[gi-1];
            end
         end
      end
   endgenerate

   assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/mpc_filter.sv
module mpc_filter #(
   parameter int              W       = 3,
   parameter int              STABLE  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] s_i,
   output logic [W-1:0] acc_o
);

   initial begin : chk_params
      assert (STABLE >= 2) else $error("mpc_filter: STABLE must be at least 2");
   end

   logic [W-1:0] last_q;
   logic [W-1:0] acc_q;
   logic         steady;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q <= RST_VAL;
         acc_q  <= RST_VAL;
      end else begin
         last_q <= s_i;
         if (steady) acc_q <= s_i;
      end
   end

   generate
      if (STABLE == 2) begin : g_pair
         assign steady = (s_i == last_q);
      end else begin : g_run
         localparam int RW = $clog2(STABLE);
         localparam logic [RW-1:0] RUN_TOP = RW'(STABLE - 2);
         logic [RW-1:0] run_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q <= '0;
            end else if (s_i == last_q) begin
               if (run_q != RUN_TOP) run_q <= run_q + 1'b1;
            end else begin
               run_q <= '0;
            end
         end

         assign steady = (s_i == last_q) && (run_q == RUN_TOP);
      end
   endgenerate

   assign acc_o = acc_q;

   AST_ACCEPT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_q != $past(acc_q)) |-> ($past(s_i) == $past(last_q))) else $error("accepted unstable pattern"); // R3

endmodule

// File: rtl/mpc_decode.sv
module mpc_decode
   import mpc_pkg::*;
(
   input  logic [PIN_W-1:0] pins_i,
   output op_mode_e         mode_o,
   output pwr_en_t          en_o,
   output logic             tx_active_o
);

   op_mode_e target;

   always_comb begin
      unique case (pins_i)
         3'b111:  mode_o = MD_WB_RUN;
         3'b101:  mode_o = MD_WB_STBY;
         3'b100:  mode_o = MD_WB_DOZE;
         3'b011:  mode_o = MD_NB_RUN;
         3'b001:  mode_o = MD_NB_STBY;
         3'b000:  mode_o = MD_NB_STBY_TR;
         3'b010:  mode_o = MD_NB_RUN_TR;
         default: mode_o = MD_WB_DOZE_TR;
      endcase
   end

   always_comb begin
      unique case (mode_o)
         MD_NB_STBY_TR: target = MD_NB_STBY;
         MD_NB_RUN_TR:  target = MD_NB_RUN;
         MD_WB_DOZE_TR: target = MD_WB_DOZE;
         default:       target = mode_o;
      endcase
   end

   always_comb begin
      en_o         = EN_AT_RESET;
      en_o.ref_div = 1'b1;
      unique case (target)
         MD_WB_RUN: begin
            en_o.wb_rx    = 1'b1;
            en_o.wb_tx    = 1'b1;
            en_o.chip_clk = 1'b1;
            en_o.tx_synth = 1'b1;
            en_o.lock_drv = 1'b1;
         end
         MD_WB_STBY: begin
            en_o.wb_rx    = 1'b1;
            en_o.chip_clk = 1'b1;
         end
         MD_NB_RUN: begin
            en_o.nb_rx    = 1'b1;
            en_o.nb_tx    = 1'b1;
            en_o.chip_clk = 1'b1;
            en_o.tx_synth = 1'b1;
            en_o.lock_drv = 1'b1;
         end
         MD_NB_STBY: begin
            en_o.nb_rx    = 1'b1;
         end
         default: ;
      endcase
   end

   assign tx_active_o = (target == MD_WB_RUN) || (target == MD_NB_RUN);

endmodule

// File: rtl/mpc_acq.sv
module mpc_acq #(
   parameter int ACQ_CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic entry_i,
   output logic pulse_o
);

   initial begin : chk_params
      assert (ACQ_CYCLES >= 1) else $error("mpc_acq: ACQ_CYCLES must be positive");
   end

   generate
      if (ACQ_CYCLES == 1) begin : g_single
         logic pulse_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse_q <= 1'b0;
            else        pulse_q <= entry_i;
         end
         assign pulse_o = pulse_q;
      end else begin : g_count
         localparam int CW = $clog2(ACQ_CYCLES + 1);
         localparam logic [CW-1:0] LOAD = CW'(ACQ_CYCLES);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (entry_i)        cnt_q <= LOAD;
            else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
         end
         assign pulse_o = (cnt_q != '0);

         AST_ACQ_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= LOAD) else $error("acquisition counter overrun"); // R12
      end
   endgenerate

endmodule

// File: rtl/mpc_top.sv
module mpc_top #(
   parameter int SYNC_STAGES   = 2,
   parameter int STABLE_CYCLES = 2,
   parameter int ACQ_CYCLES    = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       nb_sel_n,
   input  logic       stby_n,
   input  logic       doze_n,
   output logic       en_wb_rx,
   output logic       en_nb_rx,
   output logic       en_wb_tx,
   output logic       en_nb_tx,
   output logic       en_chip_clk,
   output logic       en_ref_div,
   output logic       en_tx_synth,
   output logic       lock_drive,
   output logic [2:0] mode_code,
   output logic       acq_start
);
   import mpc_pkg::*;

   logic [PIN_W-1:0] pins_raw;
   logic [PIN_W-1:0] pins_sync;
   logic [PIN_W-1:0] pins_acc;
   op_mode_e         dec_mode;
   pwr_en_t          dec_en;
   logic             dec_tx;
   pwr_en_t          en_q;
   op_mode_e         mode_q;
   logic             tx_entry;

   assign pins_raw = {nb_sel_n, stby_n, doze_n};

   mpc_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PINS_AT_RESET)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pins_raw),
      .sync_o  (pins_sync)
   );

   mpc_filter #(.W(PIN_W), .STABLE(STABLE_CYCLES), .RST_VAL(PINS_AT_RESET)) u_filter (
      .clk   (clk),
      .rst_n (rst_n),
      .s_i   (pins_sync),
      .acc_o (pins_acc)
   );

   mpc_decode u_decode (
      .pins_i      (pins_acc),
      .mode_o      (dec_mode),
      .en_o        (dec_en),
      .tx_active_o (dec_tx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= EN_AT_RESET;
         mode_q <= MD_WB_DOZE;
      end else begin
         en_q   <= dec_en;
         mode_q <= dec_mode;
      end
   end

   assign tx_entry = dec_tx && !en_q.tx_synth;

   mpc_acq #(.ACQ_CYCLES(ACQ_CYCLES)) u_acq (
      .clk     (clk),
      .rst_n   (rst_n),
      .entry_i (tx_entry),
      .pulse_o (acq_start)
   );

   assign en_wb_rx    = en_q.wb_rx;
   assign en_nb_rx    = en_q.nb_rx;
   assign en_wb_tx    = en_q.wb_tx;
   assign en_nb_tx    = en_q.nb_tx;
   assign en_chip_clk = en_q.chip_clk;
   assign en_ref_div  = en_q.ref_div;
   assign en_tx_synth = en_q.tx_synth;
   assign lock_drive  = en_q.lock_drv;
   assign mode_code   = mode_q;

   AST_REF_ALWAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      en_ref_div) else $error("reference divider disabled"); // R13
   AST_CHIP_OFF_CODES: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_code == 3'd2 || mode_code == 3'd4 || mode_code == 3'd5 || mode_code == 3'd7)
         |-> !en_chip_clk) else $error("chip clock on in off mode"); // R10
   AST_LOCK_FOLLOWS_TX: assert property (@(posedge clk) disable iff (!rst_n)
      lock_drive == (en_wb_tx || en_nb_tx)) else $error("lock driver mismatch"); // R11
   AST_TX_ONE_STANDARD: assert property (@(posedge clk) disable iff (!rst_n)
      !(en_wb_tx && en_nb_tx) && !(en_wb_rx && en_nb_rx)) else $error("both standards on"); // R7
   AST_ACQ_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(acq_start) |-> (en_tx_synth && !$past(en_tx_synth))) else $error("pulse without entry"); // R12

endmodule

// File: tb/mpc_top_bench.sv
`timescale 1ns/1ps
module mpc_top_bench;

   localparam int SYNC   = 2;
   localparam int STABLE = 2;
   localparam int ACQ    = 3;
   localparam int DEPTH  = SYNC + STABLE;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] pins = 3'b100;
   logic en_wb_rx, en_nb_rx, en_wb_tx, en_nb_tx, en_chip_clk, en_ref_div, en_tx_synth;
   logic lock_drive, acq_start;
   logic [2:0] mode_code;

   always #2 clk = ~clk;

   mpc_top #(.SYNC_STAGES(SYNC), .STABLE_CYCLES(STABLE), .ACQ_CYCLES(ACQ)) u_mpc_top (
      .clk(clk), .rst_n(rst_n),
      .nb_sel_n(pins[2]), .stby_n(pins[1]), .doze_n(pins[0]),
      .en_wb_rx(en_wb_rx), .en_nb_rx(en_nb_rx), .en_wb_tx(en_wb_tx), .en_nb_tx(en_nb_tx),
      .en_chip_clk(en_chip_clk), .en_ref_div(en_ref_div), .en_tx_synth(en_tx_synth),
      .lock_drive(lock_drive), .mode_code(mode_code), .acq_start(acq_start)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   bit live   = 0;

   // Reference model built from R1 and R4..R13
   function automatic int code_of(input logic [2:0] p);
      case (p)
         3'b111: return 0; 3'b101: return 1; 3'b100: return 2; 3'b011: return 3;
         3'b001: return 4; 3'b000: return 5; 3'b010: return 6; default: return 7;
      endcase
   endfunction

   function automatic int steady_of(input int c);
      if (c == 5) return 4;
      if (c == 6) return 3;
      if (c == 7) return 2;
      return c;
   endfunction

   function automatic logic [7:0] en_of(input int c);
      int t;
      logic [7:0] e;
      t = steady_of(c);
      e[7] = (t == 0) || (t == 1);
      e[6] = (t == 3) || (t == 4);
      e[5] = (t == 0);
      e[4] = (t == 3);
      e[3] = !((t == 2) || (t == 4));
      e[2] = 1'b1;
      e[1] = (t == 0) || (t == 3);
      e[0] = (t == 0) || (t == 3);
      return e;
   endfunction

   function automatic string tag_of(input int c);
      case (c)
         0: return "R4"; 1: return "R5"; 2: return "R6"; 3: return "R7";
         4: return "R8"; default: return "R9";
      endcase
   endfunction

   logic [2:0] hist[$];
   logic [2:0] m_acc;
   int         m_mode;
   int         m_cnt;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist.delete();
         for (int i = 0; i < DEPTH; i++) hist.push_back(3'b100);
         m_acc  = 3'b100;
         m_mode = 2;
         m_cnt  = 0;
      end else begin
         int  old_mode;
         bit  entry;
         bit  same;
         hist.push_back(pins);
         if (hist.size() > DEPTH) void'(hist.pop_front());
         old_mode = m_mode;
         m_mode   = code_of(m_acc);
         entry    = en_of(m_mode) [1] && !en_of(old_mode) [1];
         if (entry) m_cnt = ACQ;
         else if (m_cnt > 0) m_cnt--;
         same = 1;
         for (int j = 1; j < STABLE; j++) if (hist[j] != hist[0]) same = 0;
         if (same) m_acc = hist[STABLE-1];
      end
   end

   task automatic check1(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && live && !done) begin
         logic [7:0] e;
         logic [7:0] a;
         e = en_of(m_mode);
         a = {en_wb_rx, en_nb_rx, en_wb_tx, en_nb_tx, en_chip_clk, en_ref_div, en_tx_synth, lock_drive};
         check1("R1/R3", "mode_code", int'(mode_code), m_mode);
         check1(tag_of(m_mode), "rx/tx enables", int'(a[7:4]), int'(e[7:4]));
         check1("R10", "en_chip_clk", int'(a[3]), int'(e[3]));
         check1("R13", "en_ref_div", int'(a[2]), int'(e[2]));
         check1(tag_of(m_mode), "en_tx_synth", int'(a[1]), int'(e[1]));
         check1("R11", "lock_drive", int'(a[0]), int'(e[0]));
         check1("R12", "acq_start", int'(acq_start), int'(m_cnt > 0));
      end
   end

   task automatic hold(input logic [2:0] v, input int n);
      @(negedge clk);
      pins = v;
      repeat (n - 1) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   initial begin : watchdog
      #(4 * 200000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin : stim
      pins = 3'b100;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R2: reset state
      check1("R2", "reset mode_code", int'(mode_code), 2);
      check1("R2", "reset enables",
             int'({en_wb_rx, en_nb_rx, en_wb_tx, en_nb_tx, en_chip_clk, en_ref_div, en_tx_synth, lock_drive}),
             int'(8'b0000_0100));
      check1("R2", "reset acq_start", int'(acq_start), 0);
      live = 1;
      hold(3'b100, 4);

      // R3: exact latency from doze to narrowband run
      @(negedge clk);
      pins = 3'b011;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check1("R3", "mode before latency", int'(mode_code), 2);
      @(posedge clk);
      @(negedge clk);
      check1("R3", "mode after latency", int'(mode_code), 3);
      check1("R12", "pulse on entry", int'(acq_start), 1);
      repeat (8) @(negedge clk);

      hold(3'b111, 10);  // run to run: no pulse (R12)
      hold(3'b101, 10);  // R5
      hold(3'b111, 10);  // re-entry pulse
      hold(3'b010, 10);  // R9
      hold(3'b001, 10);  // R8
      hold(3'b000, 10);
      hold(3'b110, 10);
      hold(3'b100, 10);  // R6

      // R3: one-cycle glitch ignored
      hold(3'b111, 1);
      hold(3'b100, 10);
      check1("R3", "glitch ignored", int'(mode_code), 2);
      hold(3'b011, 10);
      hold(3'b101, 1);
      hold(3'b011, 10);
      check1("R3", "glitch ignored run", int'(mode_code), 3);

      // Every pattern in turn, both directions
      for (int k = 0; k < 8; k++) hold(3'(k), 9);
      for (int k = 7; k >= 0; k--) hold(3'(k), 7);
      hold(3'b101, 6);
      hold(3'b111, 6);
      hold(3'b101, 6);
      hold(3'b011, 12);
      finish_run();
   end

endmodule